// File: doc/BRIEF.md
# Interleaved Phase-Shifted Carrier PWM

This block drives a stack of series-connected boost cells from one shared duty command. Each cell has its own triangular carrier, an up/down counter that ramps from zero to a programmable peak and back. Cell k starts its ramp k/N of a full carrier period ahead of cell 0. Each cell compares the common command with its own carrier and drives a complementary pair of switches. The edges of the cells are therefore spread evenly across the period, and the summed cell voltage switches N times per carrier period.

The command is a signed word from an external current regulator. Values below zero are treated as zero, and values above the carrier peak are treated as the peak. Each cell samples the command only when its carrier passes through zero. A programmable dead time holds back every turn-on edge, so the two switches of a pair are never on together. An over-current flag blanks every gate output in the same cycle. Dropping the enable blanks the gates and parks every carrier at its start phase. The next rising edge of the enable then restarts the carriers in a known alignment.

Top module: `interleaved_pwm`

## Requirements
- R1: While `enable` is low, every gate output is low, and each carrier is held at its start phase. Cell k's start phase is k·2P/N counts along the ramp, where P is `period`. Positions at or below P sit on the rising slope at that count. Positions above P sit on the falling slope at 2P minus the position.
- R2: With P ≥ 1, each carrier is a triangle 0,1,…,P,P−1,…,1 that repeats every 2P clocks. A cell's request is high while its count is below the latched compare value C. With zero dead time, `gate_hi` is therefore high for 2C−1 of every 2P cycles when 1 ≤ C ≤ P.
- R3: Cell k's carrier leads cell 0 by k·2P/N cycles. Every gate edge of cell k comes that many cycles (modulo 2P) before the matching edge of cell 0.
- R4: Over any window of 2P consecutive cycles in steady state, the cells produce exactly N rising edges on `gate_hi` in total. This is the interleaved switching rate of N times the carrier rate.
- R5: Within a cell, `gate_lo` is the complement of `gate_hi` when the dead time is zero. `gate_hi[k]` and `gate_lo[k]` are never high in the same cycle.
- R6: A dead time of D cycles delays every rising gate edge by D cycles and leaves falling edges unchanged. Each high pulse is therefore D cycles shorter, and a request shorter than D produces no pulse.
- R7: While `trip` is high, every gate output is low in that same cycle.
- R8: A negative command acts as 0, which keeps `gate_hi` always low. A command above P acts as P, which keeps `gate_hi` high for 2P−1 of every 2P cycles.
- R9: Each cell loads the command into its compare register only on the clock edge where its carrier enters zero. A command change part-way through a period does not alter that cell's output until the period ends.
- R10: After `enable` rises, `gate_hi[0]` goes high on the (D+1)-th clock edge, provided the command is at least D+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low blanks gates and parks carriers |
| trip | input | 1 | Over-current flag; blanks all gates immediately |
| period | input | CNT_W | Carrier peak P (full carrier period is 2P clocks) |
| deadtime | input | DT_W | Turn-on delay in clock cycles |
| duty | input | CMD_W | Signed shared duty command |
| gate_hi | output | N_CELLS | Upper switch gate, one bit per cell |
| gate_lo | output | N_CELLS | Lower switch gate, one bit per cell |

## Verification
Trip and enable reach the gate outputs through combinational masking, so the bench checks them 1 ns after the input changes, inside the same cycle. A carrier compare reaches the gate one clock edge later, and the dead time adds D more edges on top of that. The enable-to-first-pulse check therefore counts samples taken after the edges from E1 to E(D+1). Duty, interleave and dead-time results are measured over whole 2P-cycle windows in steady state, so where a window starts does not matter. The valley-latching check changes the command right after a falling edge. It then measures the following low and high intervals, which must still follow the old compare value until the carrier next passes through zero.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ramp_dir_e;
endpackage

// File: rtl/ipwm_phase_preload.sv
module ipwm_phase_preload #(
    parameter int N_CELLS = 3,
    parameter int CNT_W   = 16,
    parameter int IDX     = 0
) (
    input  logic [CNT_W-1:0]   period,
    output logic [CNT_W-1:0]   start_cnt,
    output ipwm_pkg::ramp_dir_e start_dir
);
    import ipwm_pkg::*;

    localparam int PW = CNT_W + 2 + $clog2(N_CELLS + 1);
    localparam logic [PW-1:0] K_W = PW'(IDX);
    localparam logic [PW-1:0] N_W = PW'(N_CELLS);

    logic [PW-1:0] per_x;
    logic [PW-1:0] full_x;
    logic [PW-1:0] pos_x;
    logic [PW-1:0] back_x;

    always_comb begin
        per_x  = PW'(period);
        full_x = per_x << 1;
        pos_x  = (full_x * K_W) / N_W;
        back_x = full_x - pos_x;
        if (pos_x <= per_x) begin
            start_cnt = pos_x[CNT_W-1:0];
            start_dir = DIR_UP;
        end else begin
            start_cnt = back_x[CNT_W-1:0];
            start_dir = DIR_DOWN;
        end
    end
endmodule

// File: rtl/ipwm_carrier.sv
module ipwm_carrier #(
    parameter int CNT_W = 16,
    parameter int CMD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CNT_W-1:0]    period,
    input  logic signed [CMD_W-1:0] duty,
    input  logic [CNT_W-1:0]    start_cnt,
    input  ipwm_pkg::ramp_dir_e start_dir,
    output logic                req
);
    import ipwm_pkg::*;

    localparam int XW = (CNT_W > CMD_W) ? CNT_W : CMD_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ramp_dir_e        dir;
        logic [CNT_W-1:0] cmp;
    } car_st;

    car_st car_d, car_q;
    logic [CNT_W-1:0] cmd_lim;
    logic [XW-1:0]    duty_x;
    logic [XW-1:0]    per_x;

    // Clamp the signed command into 0..period
    always_comb begin
        duty_x = XW'($unsigned(duty));
        per_x  = XW'(period);
        if (duty[CMD_W-1]) begin
            cmd_lim = '0;
        end else if (duty_x > per_x) begin
            cmd_lim = period;
        end else begin
            cmd_lim = duty_x[CNT_W-1:0];
        end
    end

    always_comb begin
        car_d = car_q;
        if (!en) begin
            car_d.cnt = start_cnt;
            car_d.dir = start_dir;
            car_d.cmp = cmd_lim;
        end else begin
            if (car_q.dir == DIR_UP) begin
                if (car_q.cnt >= period) begin
                    car_d.dir = DIR_DOWN;
                    car_d.cnt = (period == '0) ? '0 : period - 1'b1;
                end else begin
                    car_d.cnt = car_q.cnt + 1'b1;
                end
            end else begin
                if (car_q.cnt == '0) begin
                    car_d.dir = DIR_UP;
                    car_d.cnt = (period == '0) ? '0 : CNT_W'(1);
                end else begin
                    car_d.cnt = car_q.cnt - 1'b1;
                end
            end
            // the compare only moves when the ramp reaches its valley
            if (car_d.cnt == '0) begin
                car_d.cmp = cmd_lim;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_q <= '{cnt: '0, dir: DIR_UP, cmp: '0};
        end else begin
            car_q <= car_d;
        end
    end

    assign req = (car_q.cnt < car_q.cmp);

    // R2: the running ramp stays within 0..period
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $stable(period)) |-> (car_q.cnt <= period));

    // R2: the running ramp moves by exactly one count per clock
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $stable(period) && period != '0 && $past(car_q.cnt) <= period)
        |-> ((car_q.cnt == $past(car_q.cnt) + 1'b1) || (car_q.cnt + 1'b1 == $past(car_q.cnt))));

    // R9: a running carrier takes a new compare value only at its valley
    a_r9_cmp_at_valley: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && (car_q.cmp != $past(car_q.cmp))) |-> (car_q.cnt == '0));
endmodule

// File: rtl/ipwm_deadband.sv
module ipwm_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            trip,
    input  logic [DT_W-1:0] deadtime,
    input  logic            req,
    output logic            hi,
    output logic            lo
);
    typedef struct packed {
        logic            req;
        logic [DT_W-1:0] age;
        logic            hi;
        logic            lo;
    } db_st;

    db_st db_d, db_q;
    logic [DT_W-1:0] age_nx;
    logic            settled;

    always_comb begin
        db_d    = db_q;
        age_nx  = '0;
        settled = 1'b0;
        if (!en || trip) begin
            db_d.req = 1'b0;
            db_d.age = '0;
            db_d.hi  = 1'b0;
            db_d.lo  = 1'b0;
        end else begin
            if (req != db_q.req) begin
                age_nx = '0;
            end else if (db_q.age != '1) begin
                age_nx = db_q.age + 1'b1;
            end else begin
                age_nx = db_q.age;
            end
            settled  = (age_nx >= deadtime);
            db_d.req = req;
            db_d.age = age_nx;
            db_d.hi  = req & settled;
            db_d.lo  = ~req & settled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_q <= '0;
        end else begin
            db_q <= db_d;
        end
    end

    assign hi = db_q.hi;
    assign lo = db_q.lo;

    // R5: the pair never conducts together
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(db_q.hi && db_q.lo));

    // R6: an upper turn-on only follows a high request
    a_r6_rise_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(db_q.hi) |-> $past(req));

    // R7: a trip clears the registered gates on the next edge
    a_r7_trip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (!db_q.hi && !db_q.lo));

    // R1: a dropped enable clears the registered gates on the next edge
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!db_q.hi && !db_q.lo));
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm #(
    parameter int N_CELLS = 3,
    parameter int CNT_W   = 16,
    parameter int CMD_W   = 16,
    parameter int DT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    trip,
    input  logic [CNT_W-1:0]        period,
    input  logic [DT_W-1:0]         deadtime,
    input  logic signed [CMD_W-1:0] duty,
    output logic [N_CELLS-1:0]      gate_hi,
    output logic [N_CELLS-1:0]      gate_lo
);
    import ipwm_pkg::*;

    logic [N_CELLS-1:0] req_w;
    logic [N_CELLS-1:0] hi_w;
    logic [N_CELLS-1:0] lo_w;
    logic [N_CELLS-1:0] run_mask;

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        logic [CNT_W-1:0] start_cnt;
        ramp_dir_e        start_dir;

        ipwm_phase_preload #(
            .N_CELLS (N_CELLS),
            .CNT_W   (CNT_W),
            .IDX     (k)
        ) u_preload (
            .period    (period),
            .start_cnt (start_cnt),
            .start_dir (start_dir)
        );

        ipwm_carrier #(
            .CNT_W (CNT_W),
            .CMD_W (CMD_W)
        ) u_carrier (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable),
            .period    (period),
            .duty      (duty),
            .start_cnt (start_cnt),
            .start_dir (start_dir),
            .req       (req_w[k])
        );

        ipwm_deadband #(
            .DT_W (DT_W)
        ) u_deadband (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (enable),
            .trip     (trip),
            .deadtime (deadtime),
            .req      (req_w[k]),
            .hi       (hi_w[k]),
            .lo       (lo_w[k])
        );
    end

    // Trip and enable blank the outputs without waiting for a clock
    assign run_mask = {N_CELLS{enable & ~trip}};
    assign gate_hi  = hi_w & run_mask;
    assign gate_lo  = lo_w & run_mask;
endmodule

// File: tb/interleaved_pwm_tb.sv
module interleaved_pwm_tb;
    localparam int N  = 3;
    localparam int CW = 16;
    localparam int MW = 16;
    localparam int DW = 8;
    localparam int P  = 30;
    localparam int FULL = 2 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic trip = 1'b0;
    logic [CW-1:0] period = CW'(P);
    logic [DW-1:0] deadtime = '0;
    logic signed [MW-1:0] duty = '0;
    logic [N-1:0] gate_hi;
    logic [N-1:0] gate_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interleaved_pwm #(.N_CELLS(N), .CNT_W(CW), .CMD_W(MW), .DT_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip), .period(period),
        .deadtime(deadtime), .duty(duty), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic restart(input int cmd, input int dt);
        enable = 1'b0;
        duty = MW'(cmd);
        deadtime = DW'(dt);
        repeat (4) tick();
    endtask

    // Counts high samples of cell 0 over one full carrier period
    task automatic measure(output int hi_n, output int lo_n, output int both_n, output int ncomp_n);
        hi_n = 0; lo_n = 0; both_n = 0; ncomp_n = 0;
        for (int i = 0; i < FULL; i++) begin
            tick();
            hi_n += int'(gate_hi[0]);
            lo_n += int'(gate_lo[0]);
            for (int k = 0; k < N; k++) begin
                if (gate_hi[k] && gate_lo[k]) both_n++;
                if (gate_hi[k] == gate_lo[k]) ncomp_n++;
            end
        end
    endtask

    task automatic t_reset();
        tick();
        chk(gate_hi == '0 && gate_lo == '0, "R1 reset gates low", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        duty = MW'(10);
        repeat (5) tick();
        chk(gate_hi == '0 && gate_lo == '0, "R1 disabled gates low", int'({gate_hi, gate_lo}), 0);
    endtask

    task automatic t_enable_latency();
        restart(10, 0);
        enable = 1'b1;
        tick();
        chk(gate_hi[0] == 1'b1, "R10 first pulse after E1 (dt=0)", int'(gate_hi[0]), 1);
    endtask

    task automatic t_duty();
        int h, l, b, c;
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == 19, "R2 high count C=10", h, 19);
        chk(l == 41, "R5 low count C=10", l, 41);
        chk(c == 0, "R5 complement dt=0", c, 0);
        restart(25, 0);
        enable = 1'b1;
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == 49, "R2 high count C=25", h, 49);
    endtask

    task automatic t_phase();
        int rise_t [N];
        logic [N-1:0] prev;
        int edges;
        restart(10, 0);
        enable = 1'b1;
        repeat (100) tick();
        for (int k = 0; k < N; k++) rise_t[k] = -1;
        prev = gate_hi;
        edges = 0;
        for (int t = 0; t < FULL; t++) begin
            tick();
            for (int k = 0; k < N; k++) begin
                if (gate_hi[k] && !prev[k]) begin
                    edges++;
                    if (rise_t[k] < 0) rise_t[k] = t;
                end
            end
            prev = gate_hi;
        end
        chk(edges == N, "R4 rising edges per carrier period", edges, N);
        for (int k = 1; k < N; k++) begin
            int lead;
            int want;
            lead = (((rise_t[0] - rise_t[k]) % FULL) + FULL) % FULL;
            want = (k * FULL) / N;
            chk(lead == want, $sformatf("R3 cell %0d lead", k), lead, want);
        end
    endtask

    task automatic t_deadtime();
        int h, l, b, c;
        bit early;
        restart(10, 4);
        enable = 1'b1;
        early = 1'b0;
        for (int e = 1; e <= 4; e++) begin
            tick();
            if (gate_hi[0]) early = 1'b1;
        end
        chk(!early, "R10 no pulse before E5 (dt=4)", int'(early), 0);
        tick();
        chk(gate_hi[0] == 1'b1, "R10 pulse after E5 (dt=4)", int'(gate_hi[0]), 1);
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == 15, "R6 high shortened by dt", h, 15);
        chk(l == 37, "R6 low shortened by dt", l, 37);
        chk(b == 0, "R5 no overlap with dt", b, 0);
        restart(3, 6);
        enable = 1'b1;
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == 0, "R6 request shorter than dt dropped", h, 0);
    endtask

    task automatic t_clamp();
        int h, l, b, c;
        restart(-5, 0);
        enable = 1'b1;
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == 0, "R8 negative command high count", h, 0);
        chk(l == FULL, "R8 negative command low count", l, FULL);
        restart(100, 0);
        enable = 1'b1;
        repeat (100) tick();
        measure(h, l, b, c);
        chk(h == FULL - 1, "R8 oversize command high count", h, FULL - 1);
    endtask

    task automatic t_valley();
        int low_n, high_n, guard;
        restart(10, 0);
        enable = 1'b1;
        repeat (100) tick();
        guard = 0;
        while (gate_hi[0] == 1'b0 && guard < 200) begin tick(); guard++; end
        while (gate_hi[0] == 1'b1 && guard < 400) begin tick(); guard++; end
        duty = MW'(25);
        low_n = 0;
        while (gate_hi[0] == 1'b0 && low_n < 200) begin low_n++; tick(); end
        high_n = 0;
        while (gate_hi[0] == 1'b1 && high_n < 200) begin high_n++; tick(); end
        chk(low_n == 41, "R9 low interval keeps old compare", low_n, 41);
        chk(high_n == 34, "R9 new compare from valley", high_n, 34);
    endtask

    task automatic t_trip();
        bit any;
        restart(25, 0);
        enable = 1'b1;
        repeat (100) tick();
        trip = 1'b1;
        #1;
        chk(gate_hi == '0 && gate_lo == '0, "R7 trip same cycle", int'({gate_hi, gate_lo}), 0);
        any = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (gate_hi != '0 || gate_lo != '0) any = 1'b1;
        end
        chk(!any, "R7 trip held", int'(any), 0);
        trip = 1'b0;
        enable = 1'b0;
        #1;
        chk(gate_hi == '0 && gate_lo == '0, "R1 disable same cycle", int'({gate_hi, gate_lo}), 0);
        duty = MW'(10);
        repeat (3) tick();
        enable = 1'b1;
        tick();
        chk(gate_hi[0] == 1'b1, "R1 carriers reparked on re-enable", int'(gate_hi[0]), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_enable_latency();
        t_duty();
        t_phase();
        t_deadtime();
        t_clamp();
        t_valley();
        t_trip();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule